// File: doc/BRIEF.md
# I2C Serial Memory Write Target

This block is the bus-facing front end of a small byte-addressed serial memory, and it handles writes only. It samples the raw SCL and SDA lines on the system clock through two-flop synchronisers. It detects START and STOP conditions and collects each byte most significant bit first. The first byte after a START is a control byte. Its upper nibble must equal a device-code parameter, its next three bits must equal the three strap pins, and its last bit must be 0, meaning write.

When the control byte matches, the target pulls SDA low for the acknowledge slot. The next byte becomes the word address and is loaded into an internal address pointer. Every later byte is acknowledged and handed to the page buffer as a one-cycle strobe carrying the byte and its target address. After each data byte the low-order page bits of the pointer advance and wrap. A STOP that follows at least one data byte fires a pulse that starts the internal write cycle. While the memory reports that a write cycle is still running, the target stays silent to its own control byte.

SDA is driven open-drain: the block only asserts an output enable that pulls the line low.

Top module: `i2c_mem_write_target`

## Requirements
- R1: START (SDA falls while SCL is high) begins a new control byte from any state. STOP (SDA rises while SCL is high) ends the transaction. Either condition releases SDA at once and restarts bit counting, and a byte cut short by STOP produces no data strobe.
- R2: A control byte of {DEV_CODE[3:0], chipSel[2:0], 1'b0}, sent MSB first, is acknowledged. sdaOe rises after the SCL fall that follows the eighth bit, stays high through the ninth SCL pulse, and drops after the following SCL fall.
- R3: A control byte whose device code differs, whose chip-select bits differ from chipSel, or whose last bit is 1 is not acknowledged. All bytes after it until the next START are also not acknowledged and produce no strobe and no write pulse.
- R4: The byte after an accepted control byte is acknowledged and loaded into the address pointer.
- R5: Each byte after the word address is acknowledged and produces a one-cycle dataValid pulse, with dataByte equal to the byte and dataAddr equal to the pointer value before the byte.
- R6: After each data byte the low PAGE_BITS bits of the pointer increment modulo 2^PAGE_BITS, and the upper bits stay unchanged.
- R7: A STOP after at least one data byte gives a single-cycle writeGo pulse. A STOP after only a control byte and address gives none.
- R8: If memBusy is high when a control byte completes, that byte is not acknowledged and the transaction is ignored until the next START.
- R9: sdaOe only changes while the synchronised SCL is low. SDA is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line (wired level) |
| sdaOe | output | 1 | Pull SDA low when 1 |
| chipSel | input | 3 | Strap value the chip-select bits must match |
| memBusy | input | 1 | Internal write cycle in progress |
| dataValid | output | 1 | One-cycle strobe for a received data byte |
| dataByte | output | 8 | Received data byte |
| dataAddr | output | ADDR_W | Address the byte belongs to |
| writeGo | output | 1 | Start the internal write cycle |

## Verification
The bench goes after a page write that starts two bytes before a page boundary. A pointer that carried into the upper bits would report the wrong addresses for the third and fourth bytes. It sends control bytes that are wrong in the device code, wrong in the chip select, or set for a read. A design that compared too few bits would acknowledge one of these, or would keep acknowledging the address and data bytes after it. It holds memBusy during a control byte, where a design that ignored it would acknowledge. It also cuts a data byte short with a STOP, and sends a STOP with no data: a careless design would emit a partial byte or a spurious write pulse.

// File: rtl/i2c_mem_write_target_pkg.sv
package i2c_mem_write_target_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {PH_IDLE, PH_CTRL, PH_ADDR, PH_DATA} phase_t;

  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic byteEnd;
  } busEvent_t;

  typedef struct packed {
    logic ackSet;
    logic ptrLoad;
    logic ptrInc;
    logic goPulse;
  } ctrlStrobe_t;
endpackage

// File: rtl/i2c_mem_write_target_sync.sv
module i2c_mem_write_target_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_mem_write_target_datapath.sv
module i2c_mem_write_target_datapath
  import i2c_mem_write_target_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  ctrlStrobe_t          strobe,
  output busEvent_t            ev,
  output logic [BYTE_W-1:0]    rxByte,
  output logic                 sclSync,
  output logic                 sdaOe,
  output logic [ADDR_W-1:0]    ptr,
  output logic                 dataValid,
  output logic [BYTE_W-1:0]    dataByte,
  output logic [ADDR_W-1:0]    dataAddr,
  output logic                 writeGo
);
  localparam int LINES   = 2;
  localparam int CNT_W   = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  logic [LINES-1:0] rawLines;
  logic [LINES-1:0] syncLines;
  logic [LINES-1:0] prevLines;

  assign rawLines = {sclIn, sdaIn};

  for (genvar g = 0; g < LINES; g++) begin : gen_sync
    i2c_mem_write_target_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .din (rawLines[g]),
      .dout(syncLines[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= syncLines;
  end

  logic sclNow, sdaNow, sclOld, sdaOld;
  assign sclNow = syncLines[1];
  assign sdaNow = syncLines[0];
  assign sclOld = prevLines[1];
  assign sdaOld = prevLines[0];
  assign sclSync = sclNow;

  logic sclRise, sclFall;
  assign sclRise = sclNow & ~sclOld;
  assign sclFall = ~sclNow & sclOld;

  logic startDet, stopDet;
  assign startDet = sclNow & sclOld & sdaOld & ~sdaNow;
  assign stopDet  = sclNow & sclOld & ~sdaOld & sdaNow;

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic              ackEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (startDet || stopDet) begin
      bitCnt <= '0;
    end else if (sclRise && bitCnt != ACK_BIT) begin
      if (bitCnt < LAST_BIT) shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      bitCnt <= bitCnt + 1'b1;
    end else if (ackEnd) begin
      bitCnt <= '0;
    end
  end

  assign ackEnd      = sclFall && bitCnt == ACK_BIT;
  assign ev.startDet = startDet;
  assign ev.stopDet  = stopDet;
  assign ev.byteEnd  = sclFall && bitCnt == LAST_BIT;
  assign rxByte      = shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           sdaOe <= 1'b0;
    else if (startDet || stopDet || ackEnd) sdaOe <= 1'b0;
    else if (strobe.ackSet)              sdaOe <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      dataValid <= 1'b0;
      dataByte  <= '0;
      dataAddr  <= '0;
      writeGo   <= 1'b0;
    end else begin
      dataValid <= strobe.ptrInc;
      writeGo   <= strobe.goPulse;
      if (strobe.ptrLoad) begin
        ptr <= ADDR_W'(shiftReg);
      end else if (strobe.ptrInc) begin
        ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
        dataByte <= shiftReg;
        dataAddr <= ptr;
      end
    end
  end
endmodule

// File: rtl/i2c_mem_write_target_control.sv
module i2c_mem_write_target_control
  import i2c_mem_write_target_pkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvent_t         ev,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [2:0]        chipSel,
  input  logic              memBusy,
  output ctrlStrobe_t       strobe,
  output phase_t            phase
);
  logic gotData;
  logic ctrlMatch;

  assign ctrlMatch = rxByte[7:4] == DEV_CODE && rxByte[3:1] == chipSel
                     && !rxByte[0] && !memBusy;

  always_comb begin
    strobe = '0;
    if (ev.stopDet) begin
      strobe.goPulse = phase == PH_DATA && gotData;
    end else if (ev.byteEnd) begin
      unique case (phase)
        PH_CTRL: strobe.ackSet = ctrlMatch;
        PH_ADDR: begin
          strobe.ackSet  = 1'b1;
          strobe.ptrLoad = 1'b1;
        end
        PH_DATA: begin
          strobe.ackSet = 1'b1;
          strobe.ptrInc = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      gotData <= 1'b0;
    end else if (ev.startDet) begin
      phase   <= PH_CTRL;
      gotData <= 1'b0;
    end else if (ev.stopDet) begin
      phase   <= PH_IDLE;
      gotData <= 1'b0;
    end else if (ev.byteEnd) begin
      unique case (phase)
        PH_CTRL: phase <= ctrlMatch ? PH_ADDR : PH_IDLE;
        PH_ADDR: phase <= PH_DATA;
        PH_DATA: gotData <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_write_target.sv
module i2c_mem_write_target
  import i2c_mem_write_target_pkg::*;
#(
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_BITS   = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [2:0]        chipSel,
  input  logic              memBusy,
  output logic              dataValid,
  output logic [BYTE_W-1:0] dataByte,
  output logic [ADDR_W-1:0] dataAddr,
  output logic              writeGo
);
  busEvent_t         ev;
  ctrlStrobe_t       strobe;
  phase_t            phase;
  logic [BYTE_W-1:0] rxByte;
  logic [ADDR_W-1:0] ptr;
  logic              sclSync;

  i2c_mem_write_target_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .ev(ev), .rxByte(rxByte), .sclSync(sclSync), .sdaOe(sdaOe), .ptr(ptr),
    .dataValid(dataValid), .dataByte(dataByte), .dataAddr(dataAddr),
    .writeGo(writeGo)
  );

  i2c_mem_write_target_control #(.DEV_CODE(DEV_CODE)) u_ctl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .chipSel(chipSel),
    .memBusy(memBusy), .strobe(strobe), .phase(phase)
  );
endmodule

// File: rtl/i2c_mem_write_target_chk.sv
module i2c_mem_write_target_chk
  import i2c_mem_write_target_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclSync,
  input logic              sdaOe,
  input logic              memBusy,
  input busEvent_t         ev,
  input ctrlStrobe_t       strobe,
  input phase_t            phase,
  input logic              dataValid,
  input logic              writeGo,
  input logic [ADDR_W-1:0] ptr
);
  // R1
  release_on_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ev.startDet || ev.stopDet) |=> !sdaOe);

  // R3
  ignore_after_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ev.byteEnd && phase == PH_IDLE) |=> !sdaOe);

  // R5
  data_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R6
  page_high_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ptrInc |=> ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS]));

  // R7
  go_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeGo |-> $past(ev.stopDet));

  // R8
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ev.byteEnd && phase == PH_CTRL && memBusy) |=> !sdaOe);

  // R9
  ack_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaOe) || $fell(sdaOe)) |-> !$past(sclSync) || ev.startDet || ev.stopDet
      || $past(ev.startDet || ev.stopDet));
endmodule

bind i2c_mem_write_target i2c_mem_write_target_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .sdaOe(sdaOe), .memBusy(memBusy),
  .ev(ev), .strobe(strobe), .phase(phase), .dataValid(dataValid),
  .writeGo(writeGo), .ptr(ptr)
);

// File: tb/i2c_mem_write_target_bench.sv
`timescale 1ns/1ps
module i2c_mem_write_target_bench;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CTRL_OK = {4'b1010, STRAP, 1'b0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic sdaDrv = 1'b1;
  logic memBusy = 1'b0;
  logic sdaOe, dataValid, writeGo;
  logic [7:0] dataByte, dataAddr;
  logic sdaLine;

  assign sdaLine = sdaDrv & ~sdaOe;

  always #4 clk = ~clk;

  i2c_mem_write_target u_i2c_mem_write_target (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .chipSel(STRAP), .memBusy(memBusy), .dataValid(dataValid),
    .dataByte(dataByte), .dataAddr(dataAddr), .writeGo(writeGo)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] capByte [0:15];
  logic [7:0] capAddr [0:15];
  int capN = 0;
  int goN = 0;
  int oeBadN = 0;
  logic prevOe = 1'b0;

  always @(negedge clk) begin
    if (dataValid && capN < 16) begin
      capByte[capN] = dataByte;
      capAddr[capN] = dataAddr;
      capN++;
    end
    if (writeGo) goN++;
    if (sdaOe != prevOe && sclLine) oeBadN++;
    prevOe = sdaOe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic clearCaps();
    capN = 0;
    goN = 0;
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sclLine = 1'b0; sdaDrv = 1'b0; waitQ();
    sclLine = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; waitQ();
      sclLine = 1'b1; waitQ(2);
      sclLine = 1'b0; waitQ();
    end
    sdaDrv = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    acked = (sdaLine == 1'b0);
    waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic t_byteWrite();
    bit a;
    clearCaps();
    startCond();
    sendByte(CTRL_OK, a); check(a, "R2 ctrl ack", a, 1);
    sendByte(8'h35, a);   check(a, "R4 addr ack", a, 1);
    sendByte(8'hA7, a);   check(a, "R5 data ack", a, 1);
    stopCond();
    check(capN == 1, "R5 strobe count", capN, 1);
    check(capByte[0] == 8'hA7, "R5 byte", capByte[0], 8'hA7);
    check(capAddr[0] == 8'h35, "R4 pointer", capAddr[0], 8'h35);
    check(goN == 1, "R7 writeGo", goN, 1);
  endtask

  task automatic t_mismatch(input logic [7:0] ctl, input string tag);
    bit a0, a1, a2;
    clearCaps();
    startCond();
    sendByte(ctl, a0);
    sendByte(8'h10, a1);
    sendByte(8'h55, a2);
    stopCond();
    check(!a0, {tag, " ctrl nack"}, a0, 0);
    check(!a1 && !a2, {tag, " later bytes nack"}, {a1, a2}, 0);
    check(capN == 0 && goN == 0, {tag, " no strobe"}, capN + goN, 0);
  endtask

  task automatic t_busy();
    bit a;
    clearCaps();
    memBusy = 1'b1;
    startCond();
    sendByte(CTRL_OK, a);
    check(!a, "R8 busy nack", a, 0);
    memBusy = 1'b0;
    sendByte(8'h20, a);
    check(!a, "R8 ignored until start", a, 0);
    stopCond();
    check(goN == 0, "R8 no writeGo", goN, 0);
    startCond();
    sendByte(CTRL_OK, a);
    check(a, "R8 ack when idle", a, 1);
    stopCond();
    check(goN == 0, "R7 no data no go", goN, 0);
  endtask

  task automatic t_pageWrap();
    bit a;
    logic [7:0] expA [0:3];
    expA[0] = 8'h3E; expA[1] = 8'h3F; expA[2] = 8'h30; expA[3] = 8'h31;
    clearCaps();
    startCond();
    sendByte(CTRL_OK, a);
    sendByte(8'h3E, a);
    for (int k = 0; k < 4; k++) sendByte(8'hC0 + 8'(k), a);
    stopCond();
    check(capN == 4, "R5 page count", capN, 4);
    for (int k = 0; k < 4; k++) begin
      check(capAddr[k] == expA[k], "R6 wrap address", capAddr[k], expA[k]);
      check(capByte[k] == 8'hC0 + 8'(k), "R5 page byte", capByte[k], 8'hC0 + k);
    end
    check(goN == 1, "R7 page go", goN, 1);
  endtask

  task automatic t_abort();
    bit a;
    clearCaps();
    startCond();
    sendByte(CTRL_OK, a);
    sendByte(8'h44, a);
    for (int i = 0; i < 3; i++) begin
      sdaDrv = 1'b1; waitQ();
      sclLine = 1'b1; waitQ(2);
      sclLine = 1'b0; waitQ();
    end
    stopCond();
    check(capN == 0, "R1 partial byte dropped", capN, 0);
    check(goN == 0, "R1 no go on abort", goN, 0);
    check(!sdaOe, "R1 released", sdaOe, 0);
    startCond();
    sendByte(CTRL_OK, a);
    check(a, "R1 fresh start acked", a, 1);
    stopCond();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    check(!sdaOe && !dataValid && !writeGo, "R1 reset idle",
          {sdaOe, dataValid, writeGo}, 0);
    rstN = 1'b1;
    waitQ(2);
    t_byteWrite();
    t_mismatch({4'b1010, 3'b100, 1'b0}, "R3 chipsel");
    t_mismatch({4'b1011, STRAP, 1'b0}, "R3 devcode");
    t_mismatch({4'b1010, STRAP, 1'b1}, "R3 read");
    t_busy();
    t_pageWrap();
    t_abort();
    check(oeBadN == 0, "R9 oe change with scl high", oeBadN, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule